// File: doc/BRIEF.md
# Four-bit accumulator ALU with carry

This block is the arithmetic core of a small nibble-wide accumulator machine. It keeps a 4-bit accumulator and a 1-bit carry flag as its only state. On each clock edge where the valid strobe is high, an operation select code picks one operation. That operation computes a new accumulator and carry from the present accumulator, the present carry and a 4-bit operand. The operand is a register or memory nibble. A separate 4-bit immediate input feeds the load-immediate operation. Both state values are driven straight to the outputs, so the surrounding decoder, register file and program sequencer can read them.

The carry has different meanings depending on the operation. After an addition it is the carry out. After a subtraction it is an inverted borrow, so 1 means no borrow occurred. Increment, decrement, decimal adjust and the carry-transfer operations each set or clear it by their own rule, given in the requirements below.

The block has a single state register pair. Its states are Reset, the post-reset Held state, and the Updated state. Reset leads to Held. In Held, a valid defined code causes the update transition. A low valid strobe or an undefined code causes the hold transition.

Top module: `nib_alu`

## Requirements
- R1: While the synchronous reset `rst` is high at a rising edge, the accumulator and carry become 0 at that edge.
- R2: At an edge where `op_valid` is low, the accumulator and carry keep their values, whatever `op_sel` and `operand` are.
- R3: Code 0 (add): {carry, acc} becomes acc + operand + carry, taken as a 5-bit sum. Bit 4 is the new carry.
- R4: Code 1 (register subtract): {carry, acc} becomes acc + carry + (~operand & 0xF). Bit 4 is the new carry, so carry set means no borrow.
- R5: Code 2 (memory subtract): {carry, acc} becomes acc + 16 − operand − carry. Bit 4 is the new carry.
- R6: Code 3 (increment): acc becomes (acc + 1) mod 16. Carry becomes 1 exactly when the new acc is 0.
- R7: Code 4 (decrement): acc becomes (acc − 1) mod 16. Carry becomes 0 exactly when the new acc is 15, and 1 otherwise.
- R8: Code 5 (rotate left): old carry enters bit 0 and old bit 3 goes to carry. Code 6 (rotate right): old carry enters bit 3 and old bit 0 goes to carry.
- R9: Code 14 (decimal adjust) works as follows when acc ≥ 10 or carry is 1. The block adds 6 to acc. If that sum is 16 or more, carry is set and acc keeps the sum mod 16. Otherwise acc takes the sum and carry is unchanged. When neither condition holds, both values stay the same.
- R10: Code 12 (carry to acc) sets acc to the old carry and clears carry. Code 13 (carry to acc plus nine) sets acc to 9 + old carry and clears carry.
- R11: Code 7 inverts all acc bits. Code 8 toggles carry. Code 9 clears both acc and carry. Code 10 clears carry. Code 11 sets carry. Codes 7, 10 and 11 leave the other state value unchanged. Code 8 leaves acc unchanged.
- R12: Code 15 loads `imm` into acc. Code 16 copies `operand` into acc. Both leave carry unchanged.
- R13: Codes 17 to 31 are undefined. With `op_valid` high they change neither acc nor carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | Applies `op_sel` at this edge when high |
| op_sel | input | 5 | Operation select code |
| operand | input | 4 | Register or memory nibble |
| imm | input | 4 | Immediate nibble for load-immediate |
| acc_q | output | 4 | Accumulator |
| carry_q | output | 1 | Carry flag |

## Verification
The hardest cases to reach are the ones that depend on a particular carry and accumulator together. Examples are decimal adjust with carry already set on a small accumulator, where carry must stay set without a wrap, and the memory subtract with carry-in of 1. The ports have no direct preload for carry. Each scenario therefore first builds its starting state from the block's own operations: it clears both values, loads the accumulator from the immediate, and then sets carry if needed. Only after that does it apply the operation under test. Rotate chains are run back to back so that the carry produced by one rotate becomes the input of the next.

// File: rtl/nib_alu_pkg.sv
package nib_alu_pkg;
    localparam int OPW = 5;

    typedef enum logic [OPW-1:0] {
        OP_ADD  = 5'd0,
        OP_SUBR = 5'd1,
        OP_SUBM = 5'd2,
        OP_INC  = 5'd3,
        OP_DEC  = 5'd4,
        OP_RL   = 5'd5,
        OP_RR   = 5'd6,
        OP_CPL  = 5'd7,
        OP_CPC  = 5'd8,
        OP_CLRB = 5'd9,
        OP_CLRC = 5'd10,
        OP_SETC = 5'd11,
        OP_C2A  = 5'd12,
        OP_C2A9 = 5'd13,
        OP_DADJ = 5'd14,
        OP_LDI  = 5'd15,
        OP_LDR  = 5'd16
    } alu_op_e;
endpackage

// File: rtl/nib_alu_arith.sv
module nib_alu_arith #(
    parameter int DW = 4
) (
    input  logic [DW-1:0] acc,
    input  logic          cy,
    input  logic [DW-1:0] opnd,
    output logic [DW:0]   add_res,
    output logic [DW:0]   subr_res,
    output logic [DW:0]   subm_res
);
    localparam logic [DW:0] WRAP = {1'b1, {DW{1'b0}}};

    logic [DW:0] acc_x, opnd_x, cy_x;

    always_comb begin
        acc_x    = {1'b0, acc};
        opnd_x   = {1'b0, opnd};
        cy_x     = {{DW{1'b0}}, cy};
        add_res  = acc_x + opnd_x + cy_x;
        subr_res = acc_x + {1'b0, ~opnd} + cy_x;
        // true result lies in 0 .. 2*WRAP-1, so modular arithmetic is exact
        subm_res = acc_x + WRAP - opnd_x - cy_x;
    end
endmodule

// File: rtl/nib_alu_step.sv
module nib_alu_step #(
    parameter int DW = 4
) (
    input  logic [DW-1:0] acc,
    input  logic          cy,
    output logic [DW-1:0] inc_acc,
    output logic          inc_cy,
    output logic [DW-1:0] dec_acc,
    output logic          dec_cy,
    output logic [DW-1:0] adj_acc,
    output logic          adj_cy
);
    localparam logic [DW-1:0] DEC_TEN = DW'(10);
    localparam logic [DW:0]   DEC_FIX = (DW+1)'(6);

    logic          need_fix;
    logic [DW:0]   fix_sum;

    always_comb begin
        inc_acc  = acc + 1'b1;
        inc_cy   = (inc_acc == '0);
        dec_acc  = acc - 1'b1;
        dec_cy   = (dec_acc != '1);
        need_fix = (acc >= DEC_TEN) || cy;
        fix_sum  = {1'b0, acc} + DEC_FIX;
        adj_acc  = need_fix ? fix_sum[DW-1:0] : acc;
        adj_cy   = (need_fix && fix_sum[DW]) ? 1'b1 : cy;
    end
endmodule

// File: rtl/nib_alu_rot.sv
module nib_alu_rot #(
    parameter int DW = 4
) (
    input  logic [DW-1:0] acc,
    input  logic          cy,
    output logic [DW-1:0] rl_acc,
    output logic          rl_cy,
    output logic [DW-1:0] rr_acc,
    output logic          rr_cy,
    output logic [DW-1:0] cpl_acc
);
    always_comb begin
        {rl_cy, rl_acc} = {acc, cy};
        {rr_acc, rr_cy} = {cy, acc};
        cpl_acc         = ~acc;
    end
endmodule

// File: rtl/nib_alu.sv
module nib_alu
    import nib_alu_pkg::*;
#(
    parameter int DW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          op_valid,
    input  logic [OPW-1:0] op_sel,
    input  logic [DW-1:0] operand,
    input  logic [DW-1:0] imm,
    output logic [DW-1:0] acc_q,
    output logic          carry_q
);
    localparam logic [DW-1:0] NINE = DW'(9);

    logic [DW:0]   add_res, subr_res, subm_res;
    logic [DW-1:0] inc_acc, dec_acc, adj_acc, rl_acc, rr_acc, cpl_acc;
    logic          inc_cy, dec_cy, adj_cy, rl_cy, rr_cy;
    logic [DW-1:0] acc_d;
    logic          cy_d;

    nib_alu_arith #(.DW(DW)) u_arith (
        .acc(acc_q), .cy(carry_q), .opnd(operand),
        .add_res(add_res), .subr_res(subr_res), .subm_res(subm_res)
    );

    nib_alu_step #(.DW(DW)) u_step (
        .acc(acc_q), .cy(carry_q),
        .inc_acc(inc_acc), .inc_cy(inc_cy),
        .dec_acc(dec_acc), .dec_cy(dec_cy),
        .adj_acc(adj_acc), .adj_cy(adj_cy)
    );

    nib_alu_rot #(.DW(DW)) u_rot (
        .acc(acc_q), .cy(carry_q),
        .rl_acc(rl_acc), .rl_cy(rl_cy),
        .rr_acc(rr_acc), .rr_cy(rr_cy),
        .cpl_acc(cpl_acc)
    );

    // next-state selection
    always_comb begin
        acc_d = acc_q;
        cy_d  = carry_q;
        if (op_valid) begin
            case (op_sel)
                OP_ADD:  {cy_d, acc_d} = add_res;
                OP_SUBR: {cy_d, acc_d} = subr_res;
                OP_SUBM: {cy_d, acc_d} = subm_res;
                OP_INC:  begin acc_d = inc_acc; cy_d = inc_cy; end
                OP_DEC:  begin acc_d = dec_acc; cy_d = dec_cy; end
                OP_RL:   begin acc_d = rl_acc;  cy_d = rl_cy;  end
                OP_RR:   begin acc_d = rr_acc;  cy_d = rr_cy;  end
                OP_CPL:  acc_d = cpl_acc;
                OP_CPC:  cy_d  = ~carry_q;
                OP_CLRB: begin acc_d = '0; cy_d = 1'b0; end
                OP_CLRC: cy_d  = 1'b0;
                OP_SETC: cy_d  = 1'b1;
                OP_C2A:  begin acc_d = {{(DW-1){1'b0}}, carry_q}; cy_d = 1'b0; end
                OP_C2A9: begin acc_d = NINE + {{(DW-1){1'b0}}, carry_q}; cy_d = 1'b0; end
                OP_DADJ: begin acc_d = adj_acc; cy_d = adj_cy; end
                OP_LDI:  acc_d = imm;
                OP_LDR:  acc_d = operand;
                default: ;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q   <= '0;
            carry_q <= 1'b0;
        end else begin
            acc_q   <= acc_d;
            carry_q <= cy_d;
        end
    end
endmodule

// File: rtl/nib_alu_chk.sv
module nib_alu_chk
    import nib_alu_pkg::*;
#(
    parameter int DW = 4
) (
    input logic           clk,
    input logic           rst,
    input logic           op_valid,
    input logic [OPW-1:0] op_sel,
    input logic [DW-1:0]  acc,
    input logic           cy
);
    AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> (acc == '0) && !cy); // R1
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !op_valid |=> $stable(acc) && $stable(cy)); // R2
    AST_INC_CARRY: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_sel == OP_INC) |=> cy == (acc == '0)); // R6
    AST_DEC_CARRY: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_sel == OP_DEC) |=> cy == (acc != '1)); // R7
    AST_ROT_LEFT: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_sel == OP_RL) |=> {cy, acc} == {$past(acc), $past(cy)}); // R8
    AST_CARRY_XFER: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_sel == OP_C2A) |=> !cy && acc == {{(DW-1){1'b0}}, $past(cy)}); // R10
    AST_CLEAR_BOTH: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_sel == OP_CLRB) |=> (acc == '0) && !cy); // R11
    AST_UNDEF_HOLD: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_sel > OP_LDR) |=> $stable(acc) && $stable(cy)); // R13
endmodule

bind nib_alu nib_alu_chk #(.DW(DW)) u_chk (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_sel(op_sel),
    .acc(acc_q), .cy(carry_q)
);

// File: tb/test_nib_alu.sv
`timescale 1ns/1ps
module test_nib_alu;
    import nib_alu_pkg::*;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       op_valid = 1'b0;
    logic [4:0] op_sel = '0;
    logic [3:0] operand = '0;
    logic [3:0] imm = '0;
    logic [3:0] acc_q;
    logic       carry_q;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    nib_alu i_nib_alu (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_sel(op_sel),
        .operand(operand), .imm(imm), .acc_q(acc_q), .carry_q(carry_q)
    );

    task automatic check(input string tag, input logic [3:0] ea, input logic ec);
        n_chk++;
        if (acc_q !== ea || carry_q !== ec) begin
            n_bad++;
            $display("FAIL %s: acc=%h exp %h, carry=%b exp %b", tag, acc_q, ea, carry_q, ec);
        end
    endtask

    // drive at falling edge, state updates at next rising edge, sample at falling edge
    task automatic apply(input logic [4:0] code, input logic [3:0] opnd, input logic [3:0] im, input logic vld);
        @(negedge clk);
        op_sel = code; operand = opnd; imm = im; op_valid = vld;
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    task automatic do_op(input alu_op_e op, input logic [3:0] opnd);
        apply(op, opnd, 4'h0, 1'b1);
    endtask

    task automatic preset(input logic [3:0] a, input logic c);
        do_op(OP_CLRB, 4'h0);
        apply(OP_LDI, 4'h0, a, 1'b1);
        if (c) do_op(OP_SETC, 4'h0);
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 reset", 4'h0, 1'b0);
        rst = 1'b0;
    endtask

    task automatic t_add;
        preset(4'h9, 1'b0); do_op(OP_ADD, 4'h8); check("R3 add overflow", 4'h1, 1'b1);
        preset(4'h1, 1'b1); do_op(OP_ADD, 4'h2); check("R3 add carry-in", 4'h4, 1'b0);
    endtask

    task automatic t_subr;
        preset(4'h5, 1'b1); do_op(OP_SUBR, 4'h3); check("R4 sub no borrow", 4'h2, 1'b1);
        preset(4'h3, 1'b1); do_op(OP_SUBR, 4'h5); check("R4 sub borrow", 4'hE, 1'b0);
    endtask

    task automatic t_subm;
        preset(4'h5, 1'b0); do_op(OP_SUBM, 4'h3); check("R5 msub", 4'h2, 1'b1);
        preset(4'h3, 1'b1); do_op(OP_SUBM, 4'h5); check("R5 msub cy-in", 4'hD, 1'b0);
        preset(4'h0, 1'b0); do_op(OP_SUBM, 4'h0); check("R5 msub zero", 4'h0, 1'b1);
    endtask

    task automatic t_incdec;
        preset(4'hF, 1'b0); do_op(OP_INC, 4'h0); check("R6 inc wrap", 4'h0, 1'b1);
        preset(4'h3, 1'b1); do_op(OP_INC, 4'h0); check("R6 inc plain", 4'h4, 1'b0);
        preset(4'h0, 1'b0); do_op(OP_DEC, 4'h0); check("R7 dec wrap", 4'hF, 1'b0);
        preset(4'h5, 1'b0); do_op(OP_DEC, 4'h0); check("R7 dec plain", 4'h4, 1'b1);
    endtask

    task automatic t_rot;
        preset(4'h6, 1'b0); do_op(OP_RL, 4'h0); check("R8 rl", 4'hC, 1'b0);
        preset(4'h8, 1'b0); do_op(OP_RR, 4'h0); check("R8 rr", 4'h4, 1'b0);
        preset(4'h7, 1'b0); do_op(OP_RR, 4'h0); check("R8 rr out", 4'h3, 1'b1);
        do_op(OP_RR, 4'h0); check("R8 rr chain", 4'h9, 1'b1);
        do_op(OP_RL, 4'h0); check("R8 rl chain", 4'h3, 1'b1);
    endtask

    task automatic t_dadj;
        preset(4'hB, 1'b0); do_op(OP_DADJ, 4'h0); check("R9 adj wrap", 4'h1, 1'b1);
        preset(4'h4, 1'b1); do_op(OP_DADJ, 4'h0); check("R9 adj cy kept", 4'hA, 1'b1);
        preset(4'h4, 1'b0); do_op(OP_DADJ, 4'h0); check("R9 adj none", 4'h4, 1'b0);
        preset(4'h9, 1'b0); do_op(OP_DADJ, 4'h0); check("R9 adj nine", 4'h9, 1'b0);
    endtask

    task automatic t_xfer;
        preset(4'h7, 1'b1); do_op(OP_C2A, 4'h0);  check("R10 c2a", 4'h1, 1'b0);
        preset(4'h2, 1'b1); do_op(OP_C2A9, 4'h0); check("R10 c2a9 set", 4'hA, 1'b0);
        preset(4'h2, 1'b0); do_op(OP_C2A9, 4'h0); check("R10 c2a9 clr", 4'h9, 1'b0);
    endtask

    task automatic t_misc;
        preset(4'h5, 1'b1); do_op(OP_CPL, 4'h0);  check("R11 cpl", 4'hA, 1'b1);
        do_op(OP_CPC, 4'h0);  check("R11 cmc", 4'hA, 1'b0);
        do_op(OP_SETC, 4'h0); check("R11 stc", 4'hA, 1'b1);
        do_op(OP_CLRC, 4'h0); check("R11 clc", 4'hA, 1'b0);
        do_op(OP_SETC, 4'h0); do_op(OP_CLRB, 4'h0); check("R11 clb", 4'h0, 1'b0);
    endtask

    task automatic t_load;
        preset(4'h0, 1'b1);
        apply(OP_LDI, 4'h3, 4'hD, 1'b1); check("R12 ldi", 4'hD, 1'b1);
        do_op(OP_LDR, 4'h6);             check("R12 ldr", 4'h6, 1'b1);
    endtask

    task automatic t_hold;
        preset(4'h9, 1'b1);
        apply(OP_ADD, 4'h7, 4'h2, 1'b0); check("R2 idle add", 4'h9, 1'b1);
        apply(OP_CLRB, 4'h0, 4'h0, 1'b0); check("R2 idle clb", 4'h9, 1'b1);
        apply(5'd20, 4'hF, 4'hF, 1'b1);  check("R13 undef 20", 4'h9, 1'b1);
        apply(5'd31, 4'h1, 4'h1, 1'b1);  check("R13 undef 31", 4'h9, 1'b1);
    endtask

    initial begin
        t_reset();
        t_add();
        t_subr();
        t_subm();
        t_incdec();
        t_rot();
        t_dadj();
        t_xfer();
        t_misc();
        t_load();
        t_hold();
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run hung, acc=%h exp n/a", acc_q);
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule